// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block sits next to a shared memory port and gives several hardware contexts load-linked / store-conditional synchronisation. It sees every access on the port. When a context does a linked read, the block records a reservation for that context on the address granule. Every write is checked against the reservation table. The block reports whether each conditional store passed, and it tells the memory whether the current write may land.

When a write goes ahead, the block drops every reservation on that granule, whichever context owns it. Each context that loses a reservation this way gets a one-cycle wake-up pulse, so a core that is parked waiting for an event can resume. The table holds one slot per context. A context never owns more than one reservation, so a context that needs a slot always finds a free one.

The write permission is combinational and valid in the request cycle, so the memory can gate its write strobe with it. The conditional-store outcome and the wake-up vector are registered and appear in the cycle after the request.

Top module: `resv_monitor`

## Requirements
- R1: Reset removes every reservation, and the registered outputs (`scDone`, `scPass`, `wakeUp`) reset to 0. A conditional store made right after reset fails.
- R2: Addresses are compared at granule level, with the low `GRAN_LOG2` address bits ignored. Two addresses that differ only in those bits name the same reservation.
- R3: A linked read from a context that already holds a reservation replaces the address of that reservation. The old address no longer lets that context's conditional store succeed.
- R4: A linked read from a context that holds no reservation creates one for that context on the masked address.
- R5: A conditional store is a request with `reqWrite=1` and `reqLinked=1`. In the request cycle, `storeAllow` is 1 exactly when the requesting context holds a reservation on the masked address. In the next cycle, `scDone` is 1 for one cycle and `scPass` carries the outcome: 1 for pass, 0 for fail.
- R6: An ordinary store (`reqWrite=1`, `reqLinked=0`) always drives `storeAllow=1` in the request cycle.
- R7: An allowed write removes every reservation whose granule equals the written granule, whatever context owns it. Reservations on other granules stay in place.
- R8: A failed conditional store leaves every reservation unchanged.
- R9: For each reservation removed by a write, `wakeUp[owner]` is 1 in the cycle after the write and for that cycle only. The `wakeUp` vector is 0 at all other times.
- R10: A request with `reqValid=0`, or a read without `reqLinked`, has no effect on the table. `storeAllow` is 0 whenever no valid write is presented. A request with both `reqRead` and `reqWrite` set is handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | An access is presented this cycle |
| reqCtx | input | CTX_W | Requesting context, below NUM_CTX |
| reqAddr | input | ADDR_W | Physical byte address |
| reqRead | input | 1 | Access is a read |
| reqWrite | input | 1 | Access is a write (takes precedence over read) |
| reqLinked | input | 1 | Linked read or conditional store |
| storeAllow | output | 1 | Write may update memory this cycle |
| scDone | output | 1 | A conditional store was resolved last cycle |
| scPass | output | 1 | Outcome of that conditional store, 1 = pass |
| wakeUp | output | NUM_CTX | Per-context wake-up pulse |

## Verification
The bench builds the block with four contexts, 8-bit addresses and 4-byte granules. At this size a few granules cover the whole reservation space, and a reference model indexed by context tracks every reservation. A pseudo-random sweep of a few thousand requests, confined to four granules with random low offsets, hits every combination of holders sharing a granule, replaced reservations, passing and failing conditional stores and multi-context wake-ups. Directed sequences come before the sweep and pin down each corner case on its own.

// File: rtl/resv_pkg.sv
package resv_pkg;
  // Strobes from the control to the reservation table
  typedef struct packed {
    logic track;   // linked read: record or move a reservation
    logic store;   // allowed write: clear matching reservations
    logic cond;    // conditional store being evaluated
  } resvStrobe_t;
endpackage

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqRead,
  input  logic        reqWrite,
  input  logic        reqLinked,
  input  logic        ownHit,
  output resvStrobe_t strobe,
  output logic        storeAllow,
  output logic        scDone,
  output logic        scPass
);
  logic isWrite;
  logic allowNow;

  always_comb begin
    isWrite      = reqValid & reqWrite;
    allowNow     = isWrite & (~reqLinked | ownHit);
    strobe.cond  = isWrite & reqLinked;
    strobe.store = allowNow;
    strobe.track = reqValid & reqRead & ~reqWrite & reqLinked;
  end

  assign storeAllow = allowNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scDone <= 1'b0;
      scPass <= 1'b0;
    end else begin
      scDone <= strobe.cond;
      scPass <= strobe.cond & allowNow;
    end
  end
endmodule

// File: rtl/resv_table.sv
module resv_table
  import resv_pkg::*;
#(
  parameter int NUM_CTX   = 4,
  parameter int CTX_W     = 2,
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  resvStrobe_t        strobe,
  input  logic [CTX_W-1:0]   reqCtx,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               ownHit,
  output logic [NUM_CTX-1:0] wakeUp
);
  localparam int TAG_W = ADDR_W - GRAN_LOG2;

  logic             entValid [NUM_CTX];
  logic [CTX_W-1:0] entCtx   [NUM_CTX];
  logic [TAG_W-1:0] entTag   [NUM_CTX];

  logic [TAG_W-1:0]   reqTag;
  logic [NUM_CTX-1:0] ctxMatch;
  logic [NUM_CTX-1:0] tagMatch;
  logic [NUM_CTX-1:0] allocOh;
  logic [NUM_CTX-1:0] writeSel;
  logic [NUM_CTX-1:0] wakeNext;
  logic               hasCtx;

  assign reqTag = reqAddr[ADDR_W-1:GRAN_LOG2];

  for (genvar e = 0; e < NUM_CTX; e++) begin : g_cmp
    assign ctxMatch[e] = entValid[e] && (entCtx[e] == reqCtx);
    assign tagMatch[e] = entValid[e] && (entTag[e] == reqTag);
  end

  assign ownHit = |(ctxMatch & tagMatch);
  assign hasCtx = |ctxMatch;

  // lowest free slot, used only when the context owns nothing yet
  always_comb begin
    logic found;
    found   = 1'b0;
    allocOh = '0;
    for (int e = 0; e < NUM_CTX; e++) begin
      if (!entValid[e] && !found) begin
        allocOh[e] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign writeSel = hasCtx ? ctxMatch : allocOh;

  always_comb begin
    wakeNext = '0;
    for (int e = 0; e < NUM_CTX; e++) begin
      for (int c = 0; c < NUM_CTX; c++) begin
        if (strobe.store && tagMatch[e] && (entCtx[e] == CTX_W'(c)))
          wakeNext[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_CTX; e++) begin
        entValid[e] <= 1'b0;
        entCtx[e]   <= '0;
        entTag[e]   <= '0;
      end
      wakeUp <= '0;
    end else begin
      for (int e = 0; e < NUM_CTX; e++) begin
        if (strobe.store && tagMatch[e]) begin
          entValid[e] <= 1'b0;
        end else if (strobe.track && writeSel[e]) begin
          entValid[e] <= 1'b1;
          entCtx[e]   <= reqCtx;
          entTag[e]   <= reqTag;
        end
      end
      wakeUp <= wakeNext;
    end
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NUM_CTX   = 4,
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 3,
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [CTX_W-1:0]   reqCtx,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqRead,
  input  logic               reqWrite,
  input  logic               reqLinked,
  output logic               storeAllow,
  output logic               scDone,
  output logic               scPass,
  output logic [NUM_CTX-1:0] wakeUp
);
  resvStrobe_t strobe;
  logic        ownHit;

  resv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqWrite(reqWrite), .reqLinked(reqLinked), .ownHit(ownHit),
    .strobe(strobe), .storeAllow(storeAllow), .scDone(scDone), .scPass(scPass)
  );

  resv_table #(
    .NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)
  ) u_table (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqCtx(reqCtx),
    .reqAddr(reqAddr), .ownHit(ownHit), .wakeUp(wakeUp)
  );
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int NUM_CTX = 4,
  parameter int ADDR_W  = 32,
  parameter int CTX_W   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [CTX_W-1:0]   reqCtx,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic               reqRead,
  input logic               reqWrite,
  input logic               reqLinked,
  input logic               storeAllow,
  input logic               scDone,
  input logic               scPass,
  input logic [NUM_CTX-1:0] wakeUp
);
  // R6
  plain_store_allowed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqLinked) |-> storeAllow);

  // R10
  no_write_no_allow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite) |-> !storeAllow);

  // R5
  sc_done_follows_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqLinked) |=> scDone);

  // R5
  sc_pass_matches_allow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqLinked) |=> (scPass == $past(storeAllow)));

  // R5
  sc_pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    scPass |-> scDone);

  // R9
  wake_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && storeAllow) |=> (wakeUp == '0));

  // R9
  wake_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|wakeUp) |=> ((wakeUp & $past(wakeUp)) == '0));
endmodule

bind resv_monitor resv_monitor_chk #(
  .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .CTX_W(CTX_W)
) u_chk (.*);

// File: tb/resv_monitor_bench.sv
`timescale 1ns/1ps
module resv_monitor_bench;
  localparam int NC = 4;
  localparam int AW = 8;
  localparam int GL = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqCtx = '0;
  logic [AW-1:0] reqAddr = '0;
  logic          reqRead = 1'b0;
  logic          reqWrite = 1'b0;
  logic          reqLinked = 1'b0;
  logic          storeAllow, scDone, scPass;
  logic [NC-1:0] wakeUp;

  always #2 clk = ~clk;

  resv_monitor #(.NUM_CTX(NC), .ADDR_W(AW), .GRAN_LOG2(GL)) u_resv_monitor (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCtx(reqCtx),
    .reqAddr(reqAddr), .reqRead(reqRead), .reqWrite(reqWrite),
    .reqLinked(reqLinked), .storeAllow(storeAllow), .scDone(scDone),
    .scPass(scPass), .wakeUp(wakeUp)
  );

  int total = 0;
  int bad = 0;

  // reference: one reservation per context
  logic          refValid [NC];
  logic [AW-1:0] refGran  [NC];
  logic          expDone, expPass;
  logic [NC-1:0] expWake;
  string         pendTag;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic v, logic [1:0] c, logic [AW-1:0] a,
                      logic rd, logic wr, logic ll);
    logic [AW-1:0] g;
    logic          isWr, allow;
    @(negedge clk);
    chk("R5", {"scDone after ", pendTag}, 32'(scDone), 32'(expDone));
    chk("R5", {"scPass after ", pendTag}, 32'(scPass), 32'(expPass));
    chk("R9", {"wakeUp after ", pendTag}, 32'(wakeUp), 32'(expWake));
    reqValid = v; reqCtx = c; reqAddr = a;
    reqRead = rd; reqWrite = wr; reqLinked = ll;
    #1;
    g     = a >> GL;
    isWr  = v && wr;
    allow = isWr && (!ll || (refValid[c] && refGran[c] == g));
    chk(tag, "storeAllow", 32'(storeAllow), 32'(allow));
    expDone = isWr && ll;
    expPass = isWr && ll && allow;
    expWake = '0;
    if (allow) begin
      for (int k = 0; k < NC; k++) begin
        if (refValid[k] && refGran[k] == g) begin
          expWake[k]  = 1'b1;
          refValid[k] = 1'b0;
        end
      end
    end else if (v && rd && !wr && ll) begin
      refValid[c] = 1'b1;
      refGran[c]  = g;
    end
    pendTag = tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int k = 0; k < NC; k++) begin refValid[k] = 1'b0; refGran[k] = '0; end
    expDone = 1'b0; expPass = 1'b0; expWake = '0; pendTag = "R1";
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1: outputs idle and no reservation after reset
    step("R1", 0, 0, 8'h00, 0, 0, 0);
    step("R1", 1, 0, 8'h10, 0, 1, 1);
    // R4: fresh reservations; R8: failed conditional leaves them
    step("R4", 1, 0, 8'h10, 1, 0, 1);
    step("R4", 1, 1, 8'h11, 1, 0, 1);
    step("R8", 1, 2, 8'h10, 0, 1, 1);
    // R2: offset within granule still matches; R7: both holders cleared
    step("R2", 1, 0, 8'h13, 0, 1, 1);
    step("R7", 1, 1, 8'h10, 0, 1, 1);
    // R3: second linked read moves the reservation
    step("R3", 1, 0, 8'h20, 1, 0, 1);
    step("R3", 1, 0, 8'h30, 1, 0, 1);
    step("R3", 1, 0, 8'h20, 0, 1, 1);
    step("R3", 1, 0, 8'h31, 0, 1, 1);
    // R6 and R7: plain store clears other context, leaves other granule
    step("R4", 1, 1, 8'h40, 1, 0, 1);
    step("R4", 1, 2, 8'h44, 1, 0, 1);
    step("R6", 1, 3, 8'h42, 0, 1, 0);
    step("R7", 1, 2, 8'h44, 0, 1, 1);
    // R10: plain read and idle cycle touch nothing
    step("R4", 1, 3, 8'h50, 1, 0, 1);
    step("R10", 1, 3, 8'h50, 1, 0, 0);
    step("R10", 0, 3, 8'h50, 0, 1, 1);
    step("R10", 1, 3, 8'h52, 0, 1, 1);
    // R10: read+write handled as plain store, wakes holder (R9)
    step("R4", 1, 0, 8'h70, 1, 0, 1);
    step("R10", 1, 1, 8'h70, 1, 1, 0);
    step("R9", 1, 0, 8'h70, 0, 1, 1);
    // sweep over four granules with random offsets
    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      logic [1:0]    kind;
      logic [AW-1:0] ad;
      lf   = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      kind = lf[1:0];
      ad   = {2'b01, 2'b00, lf[5:4], lf[7:6]};
      case (kind)
        2'd0: step("R4", 1, lf[3:2], ad, 1, 0, 1);
        2'd1: step("R5", 1, lf[3:2], ad, 0, 1, 1);
        2'd2: step("R6", lf[9] | lf[8], lf[3:2], ad, 0, 1, 0);
        default: step("R10", lf[8], lf[3:2], ad, 1, lf[11] & lf[9], 0);
      endcase
    end
    step("R9", 0, 0, 8'h00, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule